// File: doc/BRIEF.md
# Partitioned Rotating Comparand Register

This block holds a 64-bit search key that is loaded and read back sixteen bits at a time over a narrow data bus. A small segment pointer selects which 16-bit slice a write lands in or a read shows. Every access moves the pointer on by one. The pointer walks a programmable window of segment numbers and returns to the window's first segment after its last one. This lets software fill or dump only the slices it cares about, without reloading the pointer.

The key can also be rotated by one bit in either direction. The rotation is confined to the low part of the word that is used for matching. The width of that part is an input. Bits that leave one end of this part come back in at the other end. Bits above the part keep their value. The full 64-bit key is presented on an output for the compare logic that sits outside this block.

Top module: `cmpd_rotreg`

## Requirements
- R1: While `rst_n` is low, `comparand` clears to all zeros and `seg_idx` to 0. This holds even if it interrupts ongoing activity.
- R2: A cycle with `wr_en` high loads `wr_data` into segment `seg_idx`, where segment k is `comparand[16k+15:16k]`. The other three segments keep their value.
- R3: `rd_data` always shows segment `seg_idx` of the register. A read (`rd_en`) does not change `comparand`.
- R4: Each cycle with `wr_en` or `rd_en` high advances `seg_idx` exactly once, even when both are high. If `seg_idx` equals `seg_end`, it goes to `seg_start`. Otherwise it goes to `seg_idx+1` modulo 4.
- R5: With `shr` high, `shl` low and no write, bits [P-1:0] move one place toward bit 0, and old bit 0 enters bit P-1. P is the effective partition width.
- R6: With `shl` high, `shr` low and no write, bits [P-1:0] move one place toward bit P-1, and old bit P-1 enters bit 0.
- R7: Bits P and above are never changed by a rotation.
- R8: A `part_width` of 0 or greater than 64 means P = 64. A P of 1 leaves the register unchanged on rotation.
- R9: A cycle with `shl` and `shr` both high, and no write, leaves `comparand` unchanged.
- R10: When `wr_en` is high, a shift command in the same cycle is ignored. Only the segment write takes effect.
- R11: In a cycle with neither `wr_en` nor `rd_en`, `seg_idx` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write `wr_data` into the current segment |
| wr_data | input | 16 | Segment write data |
| rd_en | input | 1 | Read access; advances the segment pointer |
| rd_data | output | 16 | Contents of the current segment |
| shl | input | 1 | Rotate the partition one bit toward its MSB |
| shr | input | 1 | Rotate the partition one bit toward bit 0 |
| part_width | input | 7 | Partition width P in bits (0 or >64 means 64) |
| seg_start | input | 2 | First segment of the pointer window |
| seg_end | input | 2 | Last segment of the pointer window |
| seg_idx | output | 2 | Current segment pointer |
| comparand | output | 64 | Full register contents |

## Verification
The bench uses a single marker bit at each end of the word, so any wrap error is visible. A rotation that wrapped across the full word instead of the partition would move the marker into bit 63 instead of bit P-1. A rotation that leaked past the partition would disturb the top bit, which must stay put.

The partition widths of 0, 1 and over 64 are tried. A design that read 0 literally or ran out of range would corrupt the word or shift it where it must hold. Segment windows that start above their end are walked. A pointer that only counted up to the end, or wrapped to 0 rather than to the window start, then shows the wrong slice. A simultaneous write and read must step the pointer once, not twice. A write paired with a shift must not rotate.

// File: rtl/cmpd_pkg.sv
// Package: shared types for the partitioned comparand register.
// Assumes: at most one rotation direction is acted on per cycle.
package cmpd_pkg;

    typedef enum logic [1:0] {
        ROT_HOLD  = 2'd0,
        ROT_RIGHT = 2'd1,
        ROT_LEFT  = 2'd2
    } rot_op_e;

    // Turn the two shift commands into a single rotation request
    function automatic rot_op_e decode_rot(input logic to_msb, input logic to_lsb);
        if (to_msb && !to_lsb)      return ROT_LEFT;
        else if (to_lsb && !to_msb) return ROT_RIGHT;
        else                        return ROT_HOLD;
    endfunction

endpackage

// File: rtl/cmpd_seg_ctr.sv
// Segment pointer: steps once per access across a window [seg_start..seg_end].
// Assumes: counting is modulo 2**CNT_W, so a start above the end wraps through 0.
module cmpd_seg_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [CNT_W-1:0] seg_start,
    input  logic [CNT_W-1:0] seg_end,
    output logic [CNT_W-1:0] idx
);

    // Advance on each access, return to the window start after the end
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (step)
            idx <= (idx == seg_end) ? seg_start : idx + 1'b1;
    end

endmodule

// File: rtl/cmpd_rot_unit.sv
// Rotation network: rotates bits [P-1:0] by one place, leaves bits >= P alone.
// Assumes: part_width of 0 or above DATA_W selects the full word.
module cmpd_rot_unit
    import cmpd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int PW_W   = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [PW_W-1:0]   part_width,
    input  rot_op_e           op,
    output logic [DATA_W-1:0] dout
);

    localparam logic [PW_W-1:0] FULL_W = PW_W'(DATA_W);

    logic [PW_W-1:0]   eff_w;
    logic [PW_W-1:0]   top_pos;
    logic [DATA_W-1:0] from_above;
    logic [DATA_W-1:0] from_below;
    logic              top_bit;

    // Clamp the partition width into 1..DATA_W
    assign eff_w   = (part_width == '0 || part_width > FULL_W) ? FULL_W : part_width;
    assign top_pos = eff_w - 1'b1;

    // Fixed neighbour wiring for every bit position
    for (genvar i = 0; i < DATA_W; i++) begin : g_nb
        if (i == DATA_W - 1) begin : g_top
            assign from_above[i] = din[0];
        end else begin : g_mid_a
            assign from_above[i] = din[i+1];
        end
        if (i == 0) begin : g_bot
            assign from_below[i] = din[DATA_W-1];
        end else begin : g_mid_b
            assign from_below[i] = din[i-1];
        end
    end

    // Pick the bit that sits at the partition's top position
    always_comb begin
        top_bit = 1'b0;
        for (int j = 0; j < DATA_W; j++)
            if (PW_W'(j) == top_pos) top_bit = din[j];
    end

    // Rotate inside the partition, pass the rest through
    always_comb begin
        dout = din;
        for (int i = 0; i < DATA_W; i++) begin
            if (PW_W'(i) < eff_w) begin
                unique case (op)
                    ROT_RIGHT: dout[i] = (PW_W'(i) == top_pos) ? din[0] : from_above[i];
                    ROT_LEFT:  dout[i] = (i == 0) ? top_bit : from_below[i];
                    default:   dout[i] = din[i];
                endcase
            end
        end
    end

endmodule

// File: rtl/cmpd_rotreg.sv
// Top: 64-bit comparand register with segmented access and partition rotation.
// Assumes: DATA_W is a whole multiple of SEG_W; a write outranks any shift.
module cmpd_rotreg
    import cmpd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SEG_W  = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [SEG_W-1:0]                     wr_data,
    input  logic                                 rd_en,
    output logic [SEG_W-1:0]                     rd_data,
    input  logic                                 shl,
    input  logic                                 shr,
    input  logic [$clog2(DATA_W+1)-1:0]          part_width,
    input  logic [$clog2(DATA_W/SEG_W)-1:0]      seg_start,
    input  logic [$clog2(DATA_W/SEG_W)-1:0]      seg_end,
    output logic [$clog2(DATA_W/SEG_W)-1:0]      seg_idx,
    output logic [DATA_W-1:0]                    comparand
);

    localparam int NSEG  = DATA_W / SEG_W;
    localparam int CNT_W = $clog2(NSEG);
    localparam int PW_W  = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] key_q;
    logic [DATA_W-1:0] key_rot;
    logic [DATA_W-1:0] key_wr;
    logic [SEG_W-1:0]  seg_view [NSEG];
    rot_op_e           rot_op;

    cmpd_seg_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (wr_en | rd_en),
        .seg_start (seg_start),
        .seg_end   (seg_end),
        .idx       (seg_idx)
    );

    assign rot_op = decode_rot(shl, shr);

    cmpd_rot_unit #(.DATA_W(DATA_W), .PW_W(PW_W)) u_rot (
        .din        (key_q),
        .part_width (part_width),
        .op         (rot_op),
        .dout       (key_rot)
    );

    // Slice the register into segments for readback
    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        assign seg_view[s] = key_q[s*SEG_W +: SEG_W];
    end

    // Merge write data into the selected segment
    always_comb begin
        key_wr = key_q;
        for (int s = 0; s < NSEG; s++)
            if (CNT_W'(s) == seg_idx) key_wr[s*SEG_W +: SEG_W] = wr_data;
    end

    // Register update: write first, then rotation
    always_ff @(posedge clk) begin
        if (!rst_n)
            key_q <= '0;
        else if (wr_en)
            key_q <= key_wr;
        else if (rot_op != ROT_HOLD)
            key_q <= key_rot;
    end

    assign rd_data   = seg_view[seg_idx];
    assign comparand = key_q;

endmodule

// File: rtl/cmpd_rotreg_chk.sv
// Checker: temporal properties of the comparand register, bound to the top.
// Assumes: reset is held low from time zero for at least one edge.
module cmpd_rotreg_chk #(
    parameter int DATA_W = 64,
    parameter int SEG_W  = 16
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              wr_en,
    input logic [SEG_W-1:0]                  wr_data,
    input logic                              rd_en,
    input logic                              shl,
    input logic                              shr,
    input logic [$clog2(DATA_W/SEG_W)-1:0]   seg_start,
    input logic [$clog2(DATA_W/SEG_W)-1:0]   seg_end,
    input logic [$clog2(DATA_W/SEG_W)-1:0]   seg_idx,
    input logic [DATA_W-1:0]                 comparand
);

    localparam int NSEG  = DATA_W / SEG_W;
    localparam int CNT_W = $clog2(NSEG);

    function automatic logic [SEG_W-1:0] seg_of(input logic [DATA_W-1:0] v,
                                               input logic [CNT_W-1:0]  k);
        seg_of = '0;
        for (int s = 0; s < NSEG; s++)
            if (CNT_W'(s) == k) seg_of = v[s*SEG_W +: SEG_W];
    endfunction

    // R4: pointer steps by one inside the window
    p_adv_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || rd_en) && seg_idx != seg_end |=> seg_idx == CNT_W'($past(seg_idx) + 1'b1));

    // R4: pointer returns to the window start after the end
    p_adv_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || rd_en) && seg_idx == seg_end |=> seg_idx == $past(seg_start));

    p_idx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en || rd_en) |=> $stable(seg_idx));

    // R5 and R6: a rotation only moves bits, never creates or loses ones
    p_rot_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && (shl ^ shr) |=> $countones(comparand) == $countones($past(comparand)));

    // R9 and R3: without a write or a single shift the key is frozen
    p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && !(shl ^ shr) |=> $stable(comparand));

    // R2 and R10: a write lands in the addressed segment regardless of shifts
    p_wr_seg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> seg_of(comparand, $past(seg_idx)) == $past(wr_data));

endmodule

bind cmpd_rotreg cmpd_rotreg_chk #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .shl       (shl),
    .shr       (shr),
    .seg_start (seg_start),
    .seg_end   (seg_end),
    .seg_idx   (seg_idx),
    .comparand (comparand)
);

// File: tb/cmpd_rotreg_test.sv
module cmpd_rotreg_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, rd_en, shl, shr;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic [6:0]  part_width;
    logic [1:0]  seg_start, seg_end, seg_idx;
    logic [63:0] comparand;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [63:0] m_reg;
    logic [1:0]  m_idx;

    always #5 clk = ~clk;

    cmpd_rotreg uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .shl(shl), .shr(shr),
        .part_width(part_width), .seg_start(seg_start), .seg_end(seg_end),
        .seg_idx(seg_idx), .comparand(comparand)
    );

    typedef struct packed {
        logic        w;
        logic        r;
        logic        l;
        logic        rr;
        logic [6:0]  pw;
        logic [15:0] d;
        logic [1:0]  exp_idx;
    } vec_t;

    // Window 0..3, starting from reset; exp_idx is the pointer after the step
    localparam vec_t VECS [16] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 7'd64,  16'h1234, 2'd1},
        '{1'b1, 1'b0, 1'b0, 1'b0, 7'd64,  16'h5678, 2'd2},
        '{1'b1, 1'b0, 1'b0, 1'b0, 7'd64,  16'h9ABC, 2'd3},
        '{1'b1, 1'b0, 1'b0, 1'b0, 7'd64,  16'hDEF0, 2'd0},
        '{1'b0, 1'b1, 1'b0, 1'b0, 7'd64,  16'h0000, 2'd1},
        '{1'b0, 1'b0, 1'b0, 1'b1, 7'd64,  16'h0000, 2'd1},
        '{1'b0, 1'b0, 1'b1, 1'b0, 7'd64,  16'h0000, 2'd1},
        '{1'b0, 1'b0, 1'b0, 1'b1, 7'd16,  16'h0000, 2'd1},
        '{1'b0, 1'b0, 1'b1, 1'b1, 7'd64,  16'h0000, 2'd1},
        '{1'b1, 1'b0, 1'b1, 1'b0, 7'd64,  16'h0F0F, 2'd2},
        '{1'b0, 1'b0, 1'b1, 1'b0, 7'd0,   16'h0000, 2'd2},
        '{1'b0, 1'b0, 1'b1, 1'b0, 7'd100, 16'h0000, 2'd2},
        '{1'b1, 1'b1, 1'b0, 1'b0, 7'd64,  16'hAAAA, 2'd3},
        '{1'b0, 1'b0, 1'b0, 1'b1, 7'd1,   16'h0000, 2'd3},
        '{1'b0, 1'b1, 1'b0, 1'b0, 7'd64,  16'h0000, 2'd0},
        '{1'b0, 1'b0, 1'b0, 1'b0, 7'd64,  16'h0000, 2'd0}
    };

    function automatic logic [63:0] mdl_rot(input logic [63:0] v, input logic [6:0] pw,
                                            input logic to_msb);
        int p;
        logic [63:0] t;
        p = (pw == 0 || pw > 64) ? 64 : int'(pw);
        t = v;
        for (int i = 0; i < p; i++) begin
            if (to_msb) t[i] = (i == 0) ? v[p-1] : v[i-1];
            else        t[i] = (i == p - 1) ? v[0] : v[i+1];
        end
        return t;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic r, input logic l, input logic rr,
                         input logic [6:0] pw, input logic [15:0] d);
        wr_en = w; rd_en = r; shl = l; shr = rr; part_width = pw; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; shl = 1'b0; shr = 1'b0;
        if (w)            m_reg[int'(m_idx)*16 +: 16] = d;
        else if (l ^ rr)  m_reg = mdl_rot(m_reg, pw, l);
        if (w || r)       m_idx = (m_idx == seg_end) ? seg_start : m_idx + 2'd1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_reg = '0;
        m_idx = '0;
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.w && (v.l || v.rr)) return "R10";
        if (v.w)                  return "R2";
        if (v.r)                  return "R3";
        if (v.l && v.rr)          return "R9";
        if (v.pw == 0 || v.pw > 64 || v.pw == 1) return "R8";
        if (v.rr)                 return "R5";
        if (v.l)                  return "R6";
        return "R11";
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        wr_en = 0; rd_en = 0; shl = 0; shr = 0; wr_data = '0;
        part_width = 7'd64; seg_start = 2'd0; seg_end = 2'd3;
        do_reset();

        // R1: reset state
        chk("R1 comparand", comparand, 64'h0);
        chk("R1 seg_idx", {62'h0, seg_idx}, 64'h0);

        // Table walk
        foreach (VECS[k]) begin
            chk("R3 rd_data", {48'h0, rd_data}, {48'h0, m_reg[int'(m_idx)*16 +: 16]});
            drive(VECS[k].w, VECS[k].r, VECS[k].l, VECS[k].rr, VECS[k].pw, VECS[k].d);
            chk(tag_of(VECS[k]), comparand, m_reg);
            chk("R4 seg_idx", {62'h0, seg_idx}, {62'h0, VECS[k].exp_idx});
        end

        // R1: reset while loaded and mid-window
        drive(1'b1, 1'b0, 1'b0, 1'b0, 7'd64, 16'hFFFF);
        do_reset();
        chk("R1 mid-run comparand", comparand, 64'h0);
        chk("R1 mid-run seg_idx", {62'h0, seg_idx}, 64'h0);

        // Marker bits at both ends of the word
        drive(1'b1, 1'b0, 1'b0, 1'b0, 7'd64, 16'h0001);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 7'd64, 16'h0000);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 7'd64, 16'h0000);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 7'd64, 16'h8000);
        chk("R2 segments", comparand, 64'h8000_0000_0000_0001);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 7'd64, 16'h0);
        chk("R5 full right", comparand, 64'hC000_0000_0000_0000);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 7'd64, 16'h0);
        chk("R6 full left", comparand, 64'h8000_0000_0000_0001);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 7'd8, 16'h0);
        chk("R5 R7 part8 right", comparand, 64'h8000_0000_0000_0080);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 7'd8, 16'h0);
        chk("R6 R7 part8 left", comparand, 64'h8000_0000_0000_0001);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 7'd8, 16'h0);
        chk("R6 R7 part8 left2", comparand, 64'h8000_0000_0000_0002);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 7'd0, 16'h0);
        chk("R8 width0 right", comparand, 64'h4000_0000_0000_0001);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 7'd1, 16'h0);
        chk("R8 width1 left", comparand, 64'h4000_0000_0000_0001);

        // R4: window 1..2 entered from 0
        seg_start = 2'd1; seg_end = 2'd2;
        drive(1'b0, 1'b1, 1'b0, 1'b0, 7'd64, 16'h0);
        chk("R4 win12 a", {62'h0, seg_idx}, 64'd1);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 7'd64, 16'h0);
        chk("R4 win12 b", {62'h0, seg_idx}, 64'd2);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 7'd64, 16'h0);
        chk("R4 win12 wrap", {62'h0, seg_idx}, 64'd1);

        // R11: idle cycles keep the pointer
        repeat (3) drive(1'b0, 1'b0, 1'b0, 1'b0, 7'd64, 16'h0);
        chk("R11 hold", {62'h0, seg_idx}, 64'd1);

        // R4: window 2..0 wraps through 3
        seg_start = 2'd2; seg_end = 2'd0;
        drive(1'b0, 1'b1, 1'b0, 1'b0, 7'd64, 16'h0);
        chk("R4 win20 a", {62'h0, seg_idx}, 64'd2);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 7'd64, 16'h0);
        chk("R4 win20 b", {62'h0, seg_idx}, 64'd3);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 7'd64, 16'h0);
        chk("R4 win20 c", {62'h0, seg_idx}, 64'd0);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 7'd64, 16'h0);
        chk("R4 win20 wrap", {62'h0, seg_idx}, 64'd2);
        chk("R3 read keeps key", comparand, 64'h4000_0000_0000_0001);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule